// File: doc/BRIEF.md
# Dynamic Branch Outcome Predictor

This block keeps a small direct-mapped table of per-branch predictors and answers one question for the fetch logic: will the branch at this address be taken? The lookup port takes a branch address and returns a one-bit guess in the same cycle. The answer comes from registered table state, so it costs no extra cycle. A wrong guess costs several cycles of discarded work further down the pipe. When a branch resolves, its address and real outcome arrive on the update port, and the entry that the address maps to learns from them.

A static parameter chooses the scheme that every entry uses. In majority mode, each entry records the last three outcomes of its branches and predicts taken when at least two of them were taken. In saturating mode, each entry holds a 2-bit confidence state that climbs on taken outcomes and falls on not-taken outcomes. A counter output tracks how often an update contradicted the prediction its entry held just before the update.

The update port is a valid/ready stream. Ready is low while reset is asserted. It rises at the first clock edge after reset is released and then stays high. A beat is accepted only on an edge where valid and ready are both high. The producer must hold a beat until ready is high. After reset the block never applies back-pressure.

Top module: `branch_predictor`

## Requirements
- R1: After reset every entry predicts not taken and miss_count is 0. Internally, a majority entry holds history 000 and a saturating entry holds state 01.
- R2: The entry index is address bits [IDX_W+1:2]. Addresses that differ only in bits [1:0] or above bit IDX_W+1 share one entry. An update to one index leaves every other index unchanged.
- R3: In majority mode (SCHEME=SCH_MAJ3) an entry predicts taken (lk_taken=1) exactly when two or more of its last three accepted outcomes were taken.
- R4: In majority mode an accepted update shifts its outcome into the newest slot and drops the oldest. After taken, taken, not taken, not taken, the entry predicts not taken. It predicted taken after the third of these updates.
- R5: In saturating mode (SCHEME=SCH_SAT2) states 00 and 01 predict not taken and states 10 and 11 predict taken. A taken outcome moves the state up by one, stopping at 11. A not-taken outcome moves it down by one, stopping at 00.
- R6: Entry state changes only on an accepted update beat. Lookups and non-accepted beats have no effect on any later prediction.
- R7: lk_taken reflects lk_pc combinationally in the same cycle. When an update to the same index is accepted at the end of that cycle, lk_taken shows the value from before the update.
- R8: miss_count increases by one for each accepted update whose outcome differs from its entry's prediction before the update. It holds at all ones once it gets there.
- R9: upd_ready is 0 during reset and 1 from the first clock edge after reset release onward. A beat offered while upd_ready is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| upd_valid | input | 1 | Resolved-outcome beat present |
| upd_ready | output | 1 | Block accepts update beats |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| miss_count | output | MISS_W | Saturating count of wrong predictions |

## Verification
The bench runs one instance of each scheme on the same stimulus.

- **Directed runs.** Taken/not-taken runs on a single address tell the majority vote apart from a hysteresis state machine. The mixed order T,T,N,N shows which history bit is dropped. Repeated equal outcomes expose the saturation edges of the state machine.
- **Aliasing address pairs.** Address pairs with different upper and low bits check the index slice. A neighbouring index checks that an update does not leak to other entries.
- **Same-cycle read and write.** A lookup and an update to the same index in one cycle shows whether the read sees the old value.
- **Reset-release beat.** A beat offered while ready is still low must be dropped.
- **Random stream.** A long random stream concentrated on a few indices is compared cycle by cycle against a behavioural model. It also drives the narrow miss counter into saturation.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic {
    SCH_MAJ3 = 1'b0,
    SCH_SAT2 = 1'b1
  } scheme_e;

  localparam int HIST_LEN = 3;
  localparam logic [1:0] SAT_INIT = 2'b01;
  localparam logic [1:0] SAT_TOP  = 2'b11;
  localparam logic [1:0] SAT_BOT  = 2'b00;

  function automatic logic maj_vote(logic [HIST_LEN-1:0] h);
    int n;
    n = 0;
    for (int k = 0; k < HIST_LEN; k++) n += int'(h[k]);
    return (2 * n) > HIST_LEN;
  endfunction

  function automatic logic [1:0] sat_step(logic [1:0] s, logic t);
    if (t) return (s == SAT_TOP) ? s : s + 2'd1;
    else   return (s == SAT_BOT) ? s : s - 2'd1;
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[PC_W-1:IDX_W+2], pc[1:0]};
  assign idx = pc[IDX_W+1:2];
endmodule

// File: rtl/bp_entry.sv
module bp_entry
  import bp_pkg::*;
#(
  parameter scheme_e SCHEME = SCH_MAJ3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_taken,
  output logic pred
);
  generate
    if (SCHEME == SCH_MAJ3) begin : g_maj
      logic [HIST_LEN-1:0] hist_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hist_q <= '0;
        else if (wr_en) hist_q <= {hist_q[HIST_LEN-2:0], wr_taken};
      end

      assign pred = maj_vote(hist_q);

      AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hist_q == {$past(hist_q[HIST_LEN-2:0]), $past(wr_taken)}); // R4
      AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hist_q)); // R6
    end else begin : g_sat
      logic [1:0] st_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= SAT_INIT;
        else if (wr_en) st_q <= sat_step(st_q, wr_taken);
      end

      assign pred = st_q[1];

      AST_SAT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q != SAT_TOP) |=> st_q == 2'($past(st_q) + 2'd1)); // R5
      AST_SAT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q != SAT_BOT) |=> st_q == 2'($past(st_q) - 2'd1)); // R5
      AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)); // R6
    end
  endgenerate
endmodule

// File: rtl/bp_miss_counter.sv
module bp_miss_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (bump && cnt != CNT_MAX) cnt <= cnt + W'(1);
  end

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && cnt != CNT_MAX) |=> cnt == W'($past(cnt) + W'(1))); // R8
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump || cnt == CNT_MAX) |=> $stable(cnt)); // R8
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
  import bp_pkg::*;
#(
  parameter int      PC_W   = 32,
  parameter int      IDX_W  = 6,
  parameter int      MISS_W = 16,
  parameter scheme_e SCHEME = SCH_MAJ3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  output logic [MISS_W-1:0] miss_count
);
  localparam int N_ENT = 1 << IDX_W;

  logic             ready_q;
  logic             accept;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;
  logic [N_ENT-1:0] pred_vec;
  logic [N_ENT-1:0] wr_vec;
  logic             upd_pred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign upd_ready = ready_q;
  assign accept    = upd_valid & ready_q;

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_idx (
    .pc (lk_pc),
    .idx(lk_idx)
  );

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_idx (
    .pc (upd_pc),
    .idx(upd_idx)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign wr_vec[i] = accept & (upd_idx == IDX_W'(i));
    bp_entry #(.SCHEME(SCHEME)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_vec[i]),
      .wr_taken(upd_taken),
      .pred    (pred_vec[i])
    );
  end

  assign lk_taken = pred_vec[lk_idx];
  assign upd_pred = pred_vec[upd_idx];

  bp_miss_counter #(.W(MISS_W)) u_miss (
    .clk  (clk),
    .rst_n(rst_n),
    .bump (accept & (upd_pred != upd_taken)),
    .cnt  (miss_count)
  );

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ready |=> upd_ready); // R9
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R2
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_ready) |-> wr_vec == '0); // R6
endmodule

// File: tb/sim_branch_predictor.sv
`timescale 1ns/1ps
module sim_branch_predictor;
  import bp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  logic        lk_a, lk_b, rdy_a, rdy_b;
  logic [15:0] miss_a_o;
  logic [3:0]  miss_b_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int hist_m[64];
  int ctr_m[64];
  int miss_a = 0;
  int miss_b = 0;

  always #4 clk = ~clk;

  branch_predictor #(.PC_W(32), .IDX_W(6), .MISS_W(16), .SCHEME(SCH_MAJ3)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_a),
    .upd_valid(upd_valid), .upd_ready(rdy_a), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .miss_count(miss_a_o));

  branch_predictor #(.PC_W(32), .IDX_W(6), .MISS_W(4), .SCHEME(SCH_SAT2)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_b),
    .upd_valid(upd_valid), .upd_ready(rdy_b), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .miss_count(miss_b_o));

  function automatic int idx_of(logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic int vote(int h);
    int n;
    n = (h & 1) + ((h >> 1) & 1) + ((h >> 2) & 1);
    return (n >= 2) ? 1 : 0;
  endfunction

  function automatic int conf(int c);
    return (c >= 2) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic [31:0] lp, bit v, logic [31:0] up, bit t, string req);
    int i;
    @(negedge clk);
    lk_pc = lp; upd_valid = v; upd_pc = up; upd_taken = t;
    #1;
    check({req, " maj lookup"}, int'(lk_a), vote(hist_m[idx_of(lp)]));
    check({req, " sat lookup"}, int'(lk_b), conf(ctr_m[idx_of(lp)]));
    check("R8 maj miss_count", int'(miss_a_o), miss_a);
    check("R8 sat miss_count", int'(miss_b_o), miss_b);
    check("R9 ready", int'(rdy_a & rdy_b), 1);
    if (v) begin
      i = idx_of(up);
      if (vote(hist_m[i]) != int'(t)) miss_a++;
      if (conf(ctr_m[i]) != int'(t) && miss_b < 15) miss_b++;
      hist_m[i] = ((hist_m[i] << 1) | int'(t)) & 7;
      if (t) ctr_m[i] = (ctr_m[i] < 3) ? ctr_m[i] + 1 : 3;
      else   ctr_m[i] = (ctr_m[i] > 0) ? ctr_m[i] - 1 : 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    for (int k = 0; k < 64; k++) begin hist_m[k] = 0; ctr_m[k] = 1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      lk_pc = 32'(k * 4 + 8); #1;
      check("R1 maj reset", int'(lk_a), 0);
      check("R1 sat reset", int'(lk_b), 0);
    end
    check("R1 miss reset", int'(miss_a_o) + int'(miss_b_o), 0);
    check("R9 ready in reset", int'(rdy_a | rdy_b), 0);
    // R9: beat offered before ready rises is dropped
    @(negedge clk);
    rst_n = 1'b1; upd_valid = 1'b1; upd_pc = 32'h40; upd_taken = 1'b1;
    #1 check("R9 ready low after release", int'(rdy_a | rdy_b), 0);
    step(32'h40, 0, 32'h0, 0, "R9 dropped beat");
    step(32'h40, 0, 32'h0, 0, "R6 idle");

    // R3/R4/R5: one address, ordered outcomes
    a = 32'h100;
    step(a, 1, a, 1, "R3");
    step(a, 1, a, 1, "R3");
    step(a, 1, a, 0, "R4");
    step(a, 1, a, 0, "R4");
    step(a, 0, a, 0, "R4 after TTNN");
    for (int k = 0; k < 5; k++) step(a, 1, a, 1, "R5 climb");
    for (int k = 0; k < 5; k++) step(a, 1, a, 0, "R5 fall");
    step(a, 0, a, 0, "R5 bottom");

    // R7: same-cycle lookup and update at one index
    a = 32'h204;
    step(a, 1, a, 1, "R7");
    step(a, 1, a, 1, "R7");
    step(a, 1, a, 0, "R7");
    step(a, 0, a, 0, "R7 after");

    // R2: aliasing and neighbour isolation
    step(32'h0000_0104, 1, 32'hFFFF_0107, 1, "R2");
    step(32'h0000_0104, 1, 32'h1234_5105, 1, "R2");
    step(32'hABCD_0106, 0, 32'h0, 0, "R2 alias");
    step(32'h0000_0108, 0, 32'h0, 0, "R2 neighbour");
    step(32'h0000_0100, 0, 32'h0, 0, "R2 neighbour");

    // R6: lookups alone change nothing
    for (int k = 0; k < 8; k++) step(32'(k * 4), 0, 32'(k * 4), 1, "R6");

    // random stream on a few indices, R8 saturation on the narrow counter
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] lp, up;
      lp = {$urandom} & 32'hFFFF_FF1F;
      up = {$urandom} & 32'hFFFF_FF1F;
      step(lp, ($urandom % 4) != 0, up, $urandom % 2, "R3 R5 R7 random");
    end
    check("R8 sat counter saturated", int'(miss_b_o), 15);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule